// File: doc/BRIEF.md
# Banked GPIO Controller with Write-One Set/Clear Access

This block gives software control of up to 128 general-purpose pins, grouped into 32-bit banks. Software never writes a pin state directly. It writes a word in which every 1 bit names a pin to act on: one register drives the named pins high, a second drives them low, and a third turns them back into inputs. Any drive-high or drive-low write also makes the named pins outputs, so there is no separate register for setting a pin to output.

Reads of a bank's level register return the pin levels after a two-flop synchroniser. Two read-only snapshot words hold the levels of pins 0 to 63 as they were on the first clock after reset. Software can read them later to recover straps or board settings. The default instance has 75 pins, and every bit position above pin 74 reads as zero and drives nothing.

Top module: `banked_pin_ctrl`

## Requirements
- R1: After reset, `padOut` and `padOe` are all zero, so every pin is an input with its output latch low.
- R2: A write to the level register (bank offset 0x0) sets the output latch and the output enable of every pin whose bit is 1. Pins whose bit is 0 keep their state. Several pins can change in one write. The change is visible on the pads in the cycle after the write.
- R3: A write to the clear register (bank offset 0x4) sets the output latch low and the output enable high for every pin whose bit is 1. All other pins are unchanged.
- R4: A write to the direction-clear register (bank offset 0x8) clears the output enable of every pin whose bit is 1 and leaves every output latch unchanged.
- R5: Bank k sits at byte address k*0x20, and pin p maps to bank p/32 at bit p%32. Addresses are byte addresses and must be word aligned.
- R6: A read is captured on the clock edge where `busRdEn` is high, and `busRdData` holds the word until the next read. A level read returns the pad levels after two synchroniser flops. A read issued in the cycle after a pad change still returns the old level, and the following read returns the new level.
- R7: Bit positions at or above PIN_COUNT read as 0 in the level word, and writing 1 to them has no effect.
- R8: The snapshot word at 0x100 holds pins 0–31, and the word at 0x104 holds pins 32–63. Both are loaded from the pads on the first clock after reset is released and stay unchanged until the next reset, whatever the pads or the bus do.
- R9: Writes to unaligned addresses, to unimplemented banks, to unused offsets or to the snapshot words change nothing. Reads of write-only registers and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | ADDR_W (9) | Byte address |
| busWrData | input | 32 | Write word, one bit per pin of the bank |
| busRdData | output | 32 | Read word, registered and held between reads |
| padIn | input | PIN_COUNT (75) | Asynchronous pad input levels |
| padOut | output | PIN_COUNT (75) | Output latch per pin |
| padOe | output | PIN_COUNT (75) | Output enable per pin |

## Verification
An output latch or enable bit in the wrong state shows up on `padOut` or `padOe` one cycle after the write that caused it. Because of that, the bench sweeps all 75 pins one at a time and compares both vectors in full after every write. A wrong bank decode or a misaligned bit shows as a walking one that appears on the wrong pin or in the wrong bank word. A synchroniser with too many or too few stages shows in the first read after a pad change. A snapshot reloaded at the wrong time shows in the snapshot words read back after the pads and bus have been exercised, and again after a second reset with a different pad pattern.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_BITS   = 32;
  localparam int BANK_SLOTS  = 4;
  localparam int BANK_IDX_W  = $clog2(BANK_SLOTS);
  localparam int BANK_STRIDE = 32;
  localparam int OFS_LEVEL   = 0;
  localparam int OFS_CLEAR   = 4;
  localparam int OFS_DIRCLR  = 8;
  localparam int SNAP_BASE   = 256;

  typedef enum logic [1:0] {
    RD_HOLD  = 2'd0,
    RD_ZERO  = 2'd1,
    RD_LEVEL = 2'd2,
    RD_SNAP  = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic                  wrSet;
    logic                  wrClr;
    logic                  wrDirClr;
    logic [BANK_IDX_W-1:0] bank;
    rd_sel_e               rdSel;
    logic                  snapHi;
  } pin_strobe_t;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH = 75
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA  <= '0;
      syncOut <= '0;
    end else begin
      stageA  <= asyncIn;
      syncOut <= stageA;
    end
  end
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 9
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output pin_strobe_t       strobes
);
  localparam int BANK_LSB = $clog2(BANK_STRIDE);
  localparam int AREA_LSB = BANK_LSB + BANK_IDX_W;

  logic                  wordAligned;
  logic                  inBankArea;
  logic                  bankValid;
  logic                  inSnapArea;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic [BANK_LSB-1:0]   regOfs;

  always_comb begin
    wordAligned = (busAddr[1:0] == 2'b00);
    inBankArea  = (busAddr[ADDR_W-1:AREA_LSB] == '0);
    bankIdx     = busAddr[AREA_LSB-1:BANK_LSB];
    regOfs      = busAddr[BANK_LSB-1:0];
    bankValid   = wordAligned && inBankArea && (int'(bankIdx) < NUM_BANKS);
    inSnapArea  = wordAligned &&
                  (busAddr[ADDR_W-1:3] == (ADDR_W-3)'(SNAP_BASE / 8));
  end

  always_comb begin
    strobes          = '0;
    strobes.bank     = bankIdx;
    strobes.snapHi   = busAddr[2];
    strobes.wrSet    = busWrEn && bankValid && (regOfs == BANK_LSB'(OFS_LEVEL));
    strobes.wrClr    = busWrEn && bankValid && (regOfs == BANK_LSB'(OFS_CLEAR));
    strobes.wrDirClr = busWrEn && bankValid && (regOfs == BANK_LSB'(OFS_DIRCLR));
    if (!busRdEn)
      strobes.rdSel = RD_HOLD;
    else if (bankValid && (regOfs == BANK_LSB'(OFS_LEVEL)))
      strobes.rdSel = RD_LEVEL;
    else if (inSnapArea)
      strobes.rdSel = RD_SNAP;
    else
      strobes.rdSel = RD_ZERO;
  end
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 75
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pin_strobe_t          strobes,
  input  logic [31:0]          busWrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [31:0]          busRdData,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);
  localparam int NUM_BANKS = (PIN_COUNT + BANK_BITS - 1) / BANK_BITS;
  localparam int SNAP_W    = (PIN_COUNT < 64) ? PIN_COUNT : 64;

  logic [PIN_COUNT-1:0] padSynced;
  logic [BANK_BITS-1:0] levelWords [NUM_BANKS];
  logic [BANK_BITS-1:0] levelSel;
  logic [63:0]          snapWords;
  logic                 snapTaken;

  gpio_bank_sync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (padSynced)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_BITS;
    localparam int W  = ((PIN_COUNT - LO) < BANK_BITS) ? (PIN_COUNT - LO) : BANK_BITS;

    logic         bankHit;
    logic [W-1:0] bankOut;
    logic [W-1:0] bankOe;

    assign bankHit = (int'(strobes.bank) == b);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankOut <= '0;
        bankOe  <= '0;
      end else if (bankHit) begin
        if (strobes.wrSet) begin
          bankOut <= bankOut | busWrData[W-1:0];
          bankOe  <= bankOe  | busWrData[W-1:0];
        end else if (strobes.wrClr) begin
          bankOut <= bankOut & ~busWrData[W-1:0];
          bankOe  <= bankOe  | busWrData[W-1:0];
        end else if (strobes.wrDirClr) begin
          bankOe  <= bankOe  & ~busWrData[W-1:0];
        end
      end
    end

    assign padOut[LO +: W] = bankOut;
    assign padOe[LO +: W]  = bankOe;
    assign levelWords[b]   = BANK_BITS'(padSynced[LO +: W]);
  end

  always_comb begin
    levelSel = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(strobes.bank) == b) levelSel = levelWords[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapWords <= '0;
      snapTaken <= 1'b0;
    end else if (!snapTaken) begin
      snapWords <= 64'(padIn[SNAP_W-1:0]);
      snapTaken <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData <= '0;
    end else begin
      case (strobes.rdSel)
        RD_ZERO:  busRdData <= '0;
        RD_LEVEL: busRdData <= levelSel;
        RD_SNAP:  busRdData <= strobes.snapHi ? snapWords[63:32] : snapWords[31:0];
        default:  busRdData <= busRdData;
      endcase
    end
  end
endmodule

// File: rtl/banked_pin_ctrl.sv
module banked_pin_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 75,
  parameter int ADDR_W    = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe
);
  localparam int NUM_BANKS = (PIN_COUNT + BANK_BITS - 1) / BANK_BITS;

  pin_strobe_t strobes;

  gpio_bank_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_decode (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_bank_datapath #(.PIN_COUNT(PIN_COUNT)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWrData (busWrData),
    .padIn     (padIn),
    .busRdData (busRdData),
    .padOut    (padOut),
    .padOe     (padOe)
  );
endmodule

// File: rtl/banked_pin_ctrl_sva.sv
module banked_pin_ctrl_sva
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 75,
  parameter int ADDR_W    = 9
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busWrEn,
  input logic                 busRdEn,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [31:0]          busWrData,
  input logic [31:0]          busRdData,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe
);
  localparam int NUM_BANKS = (PIN_COUNT + BANK_BITS - 1) / BANK_BITS;
  localparam int L0        = (PIN_COUNT < BANK_BITS) ? PIN_COUNT : BANK_BITS;
  localparam int LAST_W    = PIN_COUNT - (NUM_BANKS - 1) * BANK_BITS;
  localparam logic [31:0] LAST_MASK = 32'((33'(1) << LAST_W) - 33'(1));
  localparam int BANK_AREA_LSB = $clog2(BANK_STRIDE) + BANK_IDX_W;

  logic [31:0] low0Out, low0Oe;
  logic        wrSet0, wrClr0, wrDir0, wrStray, rdLast;

  assign low0Out = 32'(padOut[L0-1:0]);
  assign low0Oe  = 32'(padOe[L0-1:0]);
  assign wrSet0  = busWrEn && (busAddr == ADDR_W'(OFS_LEVEL));
  assign wrClr0  = busWrEn && (busAddr == ADDR_W'(OFS_CLEAR));
  assign wrDir0  = busWrEn && (busAddr == ADDR_W'(OFS_DIRCLR));
  assign wrStray = busWrEn && ((busAddr[1:0] != 2'b00) ||
                               (busAddr[ADDR_W-1:BANK_AREA_LSB] != '0));
  assign rdLast  = busRdEn && (busAddr == ADDR_W'((NUM_BANKS - 1) * BANK_STRIDE));

  assert_set_drives_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrSet0 |=> (((low0Out & $past(busWrData)) == ($past(busWrData) & 32'((33'(1) << L0) - 33'(1)))) &&
                ((low0Oe  & $past(busWrData)) == ($past(busWrData) & 32'((33'(1) << L0) - 33'(1))))));

  assert_clear_drives_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrClr0 |=> ((low0Out & $past(busWrData)) == 32'd0));

  assert_dirclr_releases_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrDir0 |=> (((low0Oe & $past(busWrData)) == 32'd0) && $stable(padOut)));

  assert_top_bits_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |=> ((busRdData & ~LAST_MASK) == 32'd0));

  assert_stray_write_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrStray |=> ($stable(padOut) && $stable(padOe)));
endmodule

bind banked_pin_ctrl banked_pin_ctrl_sva #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .padOut    (padOut),
  .padOe     (padOe)
);

// File: tb/test_banked_pin_ctrl.sv
module test_banked_pin_ctrl;
  localparam int PINS = 75;
  localparam logic [PINS-1:0] BOOT_A = {11'h5A3, 32'hDEADBEEF, 32'h12345678};
  localparam logic [PINS-1:0] BOOT_B = {11'h0F0, 32'hCAFE0042, 32'h8765ABCD};

  logic            clk = 1'b0;
  logic            rstN;
  logic            busWrEn, busRdEn;
  logic [8:0]      busAddr;
  logic [31:0]     busWrData, busRdData;
  logic [PINS-1:0] padIn, padOut, padOe;
  logic [PINS-1:0] expOut, expOe;
  logic [31:0]     rd;
  int              checks = 0;
  int              failures = 0;
  bit              done = 1'b0;

  always #4 clk = ~clk;

  banked_pin_ctrl i_banked_pin_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic checkPads(input string req);
    chk(req, padOut, expOut);
    chk(req, padOe, expOe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0; busAddr = '0; busWrData = '0;
    padIn = BOOT_A; expOut = '0; expOe = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkPads("R1 reset state");

    busRead(9'h100, rd); chk("R8 snapshot low", rd, 32'h12345678);
    busRead(9'h104, rd); chk("R8 snapshot high", rd, 32'hDEADBEEF);
    busRead(9'h108, rd); chk("R9 unmapped read", rd, 32'h0);

    // R2 R5: walking set over every pin
    for (int p = 0; p < PINS; p++) begin
      busWrite(9'((p / 32) * 32), 32'(1) << (p % 32));
      expOut[p] = 1'b1; expOe[p] = 1'b1;
      checkPads("R2 R5 single set");
    end

    // R3: multi-pin clear per bank
    for (int b = 0; b < 3; b++) begin
      logic [31:0] pat = 32'hA5A5A5A5 ^ (32'h11111111 * b);
      busWrite(9'(b * 32 + 4), pat);
      for (int i = 0; i < 32; i++)
        if (b * 32 + i < PINS && pat[i]) begin expOut[b*32+i] = 1'b0; expOe[b*32+i] = 1'b1; end
      checkPads("R3 clear");
    end

    // R4: release direction, latches stay
    for (int b = 0; b < 3; b++) begin
      busWrite(9'(b * 32 + 8), 32'h0F0F0F0F);
      for (int i = 0; i < 32; i++)
        if (b * 32 + i < PINS && i % 8 < 4) expOe[b*32+i] = 1'b0;
      checkPads("R4 dirclr");
    end

    // R3: clear re-enables output on released pins
    busWrite(9'h04, 32'h00000003);
    expOut[1:0] = 2'b00; expOe[1:0] = 2'b11;
    checkPads("R3 clear sets output");

    // R7: set all bits of the partial bank
    busWrite(9'h40, 32'hFFFFFFFF);
    expOut[74:64] = '1; expOe[74:64] = '1;
    checkPads("R7 partial bank set");

    // R9: stray writes leave pads alone
    busWrite(9'h60, 32'hFFFFFFFF); checkPads("R9 unimplemented bank write");
    busWrite(9'h01, 32'hFFFFFFFF); checkPads("R9 unaligned write");
    busWrite(9'h0C, 32'hFFFFFFFF); checkPads("R9 unused offset write");
    busWrite(9'h104, 32'h0);       checkPads("R9 snapshot write");
    busRead(9'h04, rd); chk("R9 clear reads zero", rd, 32'h0);
    busRead(9'h08, rd); chk("R9 dirclr reads zero", rd, 32'h0);
    busRead(9'h60, rd); chk("R9 missing bank reads zero", rd, 32'h0);

    // R5 R6: walking input one over every pin and every bank
    for (int p = 0; p < PINS; p++) begin
      padIn = PINS'(1) << p;
      repeat (2) @(negedge clk);
      for (int b = 0; b < 3; b++) begin
        busRead(9'(b * 32), rd);
        chk("R5 R6 level walk", rd, (b == p / 32) ? (32'(1) << (p % 32)) : 32'h0);
      end
    end

    // R7: unimplemented bits read zero
    padIn = '1;
    repeat (2) @(negedge clk);
    busRead(9'h40, rd); chk("R7 top bits zero", rd, 32'h000007FF);

    // R6: synchroniser latency and read hold
    busRead(9'h00, rd); chk("R6 settled level", rd, 32'hFFFFFFFF);
    padIn = '0;
    busRead(9'h00, rd); chk("R6 old level first read", rd, 32'hFFFFFFFF);
    busRead(9'h00, rd); chk("R6 new level second read", rd, 32'h0);
    padIn = '1;
    repeat (4) @(negedge clk);
    chk("R6 data held between reads", busRdData, 32'h0);

    // R8: snapshot unaffected by pad and bus activity
    busRead(9'h100, rd); chk("R8 snapshot low kept", rd, 32'h12345678);
    busRead(9'h104, rd); chk("R8 snapshot high kept", rd, 32'hDEADBEEF);

    // R1 R8: second reset with new pattern
    @(negedge clk);
    padIn = BOOT_B; rstN = 1'b0;
    repeat (2) @(negedge clk);
    expOut = '0; expOe = '0;
    checkPads("R1 reset again");
    rstN = 1'b1;
    @(negedge clk);
    padIn = '0;
    busRead(9'h100, rd); chk("R8 recapture low", rd, 32'h8765ABCD);
    busRead(9'h104, rd); chk("R8 recapture high", rd, 32'hCAFE0042);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule